// File: doc/BRIEF.md
# USB Transmit Endpoint Handshake Status

This block keeps the transmit-side handshake state of one device endpoint. It holds the DATA0/DATA1 sequence bit that picks the PID of the next outgoing data packet. The bit flips when the host acknowledges a packet or when a SETUP token arrives. Firmware may overwrite the bit, but only in a write that also sets an override bit.

The block also applies two optional modes to an IN token that is answered with NAK because the endpoint has no data ready (occupancy code 00):

- **Interrupt mode** records a void flag and an interrupt pending bit, and drives an active-low interrupt request.
- **Data-available mode** records a data-available flag and drives an output pin when the board-level enable is on.

Both modes depend on a global feature enable. With the modes and the enables all cleared, an empty-buffer NAK leaves every flag as it was, which is the legacy behaviour.

Firmware sees two byte registers. Register 0 is the status register. Register 1 is the event register. Each register is written through a shared write port and read back through a combinational read port.

Top module: `usb_tx_ep_status`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00, `pid_seq` is 0, `irq_n` is 1 and `dsa_out` is 0.
- R2: `pid_seq` always equals status bit 0, the sequence bit.
- R3: A valid ACK (`ack_ok`) toggles the sequence bit on the next edge.
- R4: A valid SETUP (`setup_ok`) toggles the sequence bit on the next edge.
- R5: A status write with bit 1 (override) set loads bit 0 into the sequence bit. This write takes precedence over a same-cycle ACK or SETUP. A status write with bit 1 clear leaves the sequence bit unchanged.
- R6: Status bit 1 always reads 0. Status bits 7:5 and event bits 7:2 also always read 0.
- R7: Status bit 2 enables interrupt mode. When it is set and `feat_en` is 1, a NAK with `occ` = 00 sets the void flag (status bit 4) and the pending bit (event bit 0). `irq_n` is low while the pending bit is set and `irq_en` is 1. The pending bit stays set until firmware clears it.
- R8: Status bit 3 enables data-available mode. When it is set and `feat_en` is 1, a NAK with `occ` = 00 sets the data-available flag (event bit 1). `dsa_out` equals that flag ANDed with `board_en`.
- R9: A NAK with `occ` other than 00 changes no flag.
- R10: With `feat_en` = 0, a NAK with `occ` = 00 changes no flag, whatever the mode bits hold.
- R11: Writing 1 to status bit 4, event bit 0 or event bit 1 clears that flag. Writing 0 leaves the flag unchanged. A set from a NAK in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_ok | input | 1 | Valid ACK handshake received from the host |
| setup_ok | input | 1 | Valid SETUP token received |
| in_nak | input | 1 | IN token answered with NAK |
| occ | input | 2 | Data-set occupancy code of the endpoint |
| feat_en | input | 1 | Global enable for the NAK modes |
| board_en | input | 1 | Enable for the data-available output pin |
| irq_en | input | 1 | Interrupt request enable |
| wr_en | input | 1 | Firmware write strobe |
| wr_addr | input | 1 | Write target: 0 selects status, 1 selects event |
| wr_data | input | 8 | Firmware write data |
| rd_addr | input | 1 | Read select: 0 selects status, 1 selects event |
| rd_data | output | 8 | Read data for the selected register |
| pid_seq | output | 1 | Sequence bit for the next data PID (0 = DATA0, 1 = DATA1) |
| irq_n | output | 1 | Interrupt request, active low |
| dsa_out | output | 1 | Data-available indication |

## Verification
The bench builds the block with its default parameters: a byte-wide register port, the bit positions stated in the requirements, and a 2-bit occupancy code. With the 2-bit code, the empty code and the non-empty codes can each be driven against both modes. The default positions let the vector table name every field value directly. With these settings the bench can reach same-cycle collisions, such as an override write against an ACK and a clear against a set. It also covers the gating of each mode by `feat_en`, `irq_en` and `board_en`.

// File: rtl/usb_tx_ep_status.sv
module usb_tx_ep_status #(
  parameter int DW     = 8,
  parameter int OCC_W  = 2,
  parameter int SEQ_B  = 0,
  parameter int OVR_B  = 1,
  parameter int NIRQ_B = 2,
  parameter int DSAM_B = 3,
  parameter int VOID_B = 4,
  parameter int PEND_B = 0,
  parameter int DSAF_B = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_ok,
  input  logic             setup_ok,
  input  logic             in_nak,
  input  logic [OCC_W-1:0] occ,
  input  logic             feat_en,
  input  logic             board_en,
  input  logic             irq_en,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             pid_seq,
  output logic             irq_n,
  output logic             dsa_out
);

  logic seq, nirq_mode, dsa_mode, void_f, pend_f, dsa_f;

  wire wr_st     = wr_en & ~wr_addr;
  wire wr_ev     = wr_en & wr_addr;
  wire ovr_wr    = wr_st & wr_data[OVR_B];
  wire empty_nak = in_nak & (occ == '0) & feat_en;
  wire set_void  = empty_nak & nirq_mode;
  wire set_dsa   = empty_nak & dsa_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= 1'b0;
      nirq_mode <= 1'b0;
      dsa_mode  <= 1'b0;
      void_f    <= 1'b0;
      pend_f    <= 1'b0;
      dsa_f     <= 1'b0;
    end else begin
      if (ovr_wr)
        seq <= wr_data[SEQ_B];
      else if (ack_ok | setup_ok)
        seq <= ~seq;
      if (wr_st) begin
        nirq_mode <= wr_data[NIRQ_B];
        dsa_mode  <= wr_data[DSAM_B];
      end
      void_f <= set_void | (void_f & ~(wr_st & wr_data[VOID_B]));
      pend_f <= set_void | (pend_f & ~(wr_ev & wr_data[PEND_B]));
      dsa_f  <= set_dsa  | (dsa_f  & ~(wr_ev & wr_data[DSAF_B]));
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_addr) begin
      rd_data[SEQ_B]  = seq;
      rd_data[NIRQ_B] = nirq_mode;
      rd_data[DSAM_B] = dsa_mode;
      rd_data[VOID_B] = void_f;
    end else begin
      rd_data[PEND_B] = pend_f;
      rd_data[DSAF_B] = dsa_f;
    end
  end

  assign pid_seq = seq;
  assign irq_n   = ~(pend_f & irq_en);
  assign dsa_out = dsa_f & board_en;

  assert_ack_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !setup_ok && !ovr_wr) |=> (pid_seq != $past(pid_seq)));

  assert_setup_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_ok && !ack_ok && !ovr_wr) |=> (pid_seq != $past(pid_seq)));

  assert_plain_write_keeps_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !wr_data[OVR_B] && !ack_ok && !setup_ok) |=> $stable(pid_seq));

  assert_pend_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_f && !(wr_en && wr_addr && wr_data[PEND_B])) |=> pend_f);

  assert_full_nak_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_nak && occ != '0 && !wr_en) |=> ($stable(void_f) && $stable(pend_f) && $stable(dsa_f)));

  assert_legacy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_en && !wr_en) |=> ($stable(void_f) && $stable(pend_f) && $stable(dsa_f)));

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_void) |=> (void_f && pend_f));

endmodule

// File: tb/usb_tx_ep_status_test.sv
module usb_tx_ep_status_test;
  localparam int CLK_P = 10;
  localparam int NV = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ack_ok = 0, setup_ok = 0, in_nak = 0, feat_en = 0, board_en = 0, irq_en = 0;
  logic [1:0] occ = 2'b00;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic pid_seq, irq_n, dsa_out;
  int runs = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  usb_tx_ep_status uut (
    .clk(clk), .rst_n(rst_n), .ack_ok(ack_ok), .setup_ok(setup_ok), .in_nak(in_nak),
    .occ(occ), .feat_en(feat_en), .board_en(board_en), .irq_en(irq_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pid_seq(pid_seq), .irq_n(irq_n), .dsa_out(dsa_out)
  );

  function automatic logic [39:0] v(input logic w, wa, input logic [7:0] d,
      input logic ak, su, nk, input logic [1:0] oc, input logic f, b, ie,
      input logic [7:0] es, ee, input logic irqn, dsa, input logic [3:0] rq);
    return {w, wa, d, ak, su, nk, oc, f, b, ie, es, ee, irqn, dsa, rq};
  endfunction

  localparam logic [39:0] VEC [NV] = '{
    v(0,0,8'h00, 0,0,0,2'b00, 0,0,0, 8'h00,8'h00,1,0, 4'd1),  // R1 idle
    v(0,0,8'h00, 1,0,0,2'b00, 0,0,0, 8'h01,8'h00,1,0, 4'd3),  // R3 ack
    v(0,0,8'h00, 0,1,0,2'b00, 0,0,0, 8'h00,8'h00,1,0, 4'd4),  // R4 setup
    v(1,0,8'h01, 0,0,0,2'b00, 0,0,0, 8'h00,8'h00,1,0, 4'd5),  // R5 no override
    v(1,0,8'h03, 0,0,0,2'b00, 0,0,0, 8'h01,8'h00,1,0, 4'd6),  // R5 R6 override
    v(1,0,8'h02, 1,0,0,2'b00, 0,0,0, 8'h00,8'h00,1,0, 4'd5),  // R5 override beats ack
    v(1,0,8'h04, 0,0,0,2'b00, 0,0,0, 8'h04,8'h00,1,0, 4'd7),  // R7 enable mode
    v(0,0,8'h00, 0,0,1,2'b01, 1,0,1, 8'h04,8'h00,1,0, 4'd9),  // R9 occ 01
    v(0,0,8'h00, 0,0,1,2'b00, 0,0,1, 8'h04,8'h00,1,0, 4'd10), // R10 feat off
    v(0,0,8'h00, 0,0,1,2'b00, 1,0,1, 8'h14,8'h01,0,0, 4'd7),  // R7 empty nak
    v(0,0,8'h00, 0,0,0,2'b00, 1,0,1, 8'h14,8'h01,0,0, 4'd7),  // R7 holds
    v(0,0,8'h00, 0,0,0,2'b00, 1,0,0, 8'h14,8'h01,1,0, 4'd7),  // R7 irq_en gate
    v(1,0,8'h04, 0,0,0,2'b00, 1,0,0, 8'h14,8'h01,1,0, 4'd11), // R11 write 0 keeps void
    v(1,0,8'h14, 0,0,0,2'b00, 1,0,0, 8'h04,8'h01,1,0, 4'd11), // R11 clear void
    v(1,1,8'h01, 0,0,0,2'b00, 1,0,1, 8'h04,8'h00,1,0, 4'd11), // R11 clear pend
    v(1,0,8'h08, 0,0,0,2'b00, 1,0,0, 8'h08,8'h00,1,0, 4'd8),  // R8 dsa mode
    v(0,0,8'h00, 0,0,1,2'b00, 1,0,0, 8'h08,8'h02,1,0, 4'd8),  // R8 flag, pin gated
    v(0,0,8'h00, 0,0,0,2'b00, 1,1,0, 8'h08,8'h02,1,1, 4'd8),  // R8 board on
    v(1,1,8'h02, 0,0,0,2'b00, 1,1,0, 8'h08,8'h00,1,0, 4'd11), // R11 clear dsa
    v(0,0,8'h00, 0,0,1,2'b11, 1,1,0, 8'h08,8'h00,1,0, 4'd9),  // R9 occ 11
    v(1,0,8'h0C, 0,0,0,2'b00, 1,1,1, 8'h0C,8'h00,1,0, 4'd7),  // R7 R8 both modes
    v(0,0,8'h00, 0,0,1,2'b00, 1,1,1, 8'h1C,8'h03,0,1, 4'd8),  // R7 R8 both fire
    v(1,1,8'h03, 0,0,1,2'b00, 1,1,1, 8'h1C,8'h03,0,1, 4'd11)  // R11 set beats clear
  };

  task automatic chk(input string what, input int rq, input logic [7:0] act, exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic observe(input int rq, input logic [7:0] es, ee, input logic irqn, dsa);
    rd_addr = 0; #1;
    chk("status", rq, rd_data, es);
    chk("pid_seq R2", rq, {7'd0, pid_seq}, {7'd0, es[0]});
    rd_addr = 1; #1;
    chk("event", rq, rd_data, ee);
    chk("irq_n", rq, {7'd0, irq_n}, {7'd0, irqn});
    chk("dsa_out", rq, {7'd0, dsa_out}, {7'd0, dsa});
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2 observe(1, 8'h00, 8'h00, 1, 0);  // R1 reset state
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, wr_addr, wr_data, ack_ok, setup_ok, in_nak, occ, feat_en, board_en, irq_en} = VEC[i][39:22];
      @(posedge clk); #2;
      {wr_en, ack_ok, setup_ok, in_nak} = '0;
      observe(int'(VEC[i][3:0]), VEC[i][21:14], VEC[i][13:6], VEC[i][5], VEC[i][4]);
    end
    // R3: repeated acks alternate DATA0/DATA1
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) ack_ok = 1;
      @(posedge clk); #2 ack_ok = 0;
      chk("ack run R3", 3, {7'd0, pid_seq}, {7'd0, logic'(k[0] == 1'b0)});
    end
    // R1: reset mid-run clears everything
    @(negedge clk) rst_n = 0;
    @(posedge clk); #2;
    observe(1, 8'h00, 8'h00, 1, 0);
    @(negedge clk) rst_n = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule